// File: doc/BRIEF.md
# Program Memory Lock and Scrambled Readout Controller

This block sits between a microcontroller's on-chip program memory and the pins used by an external programmer. The programmer picks an operation on a three-bit operation field. It supplies an address and a data byte, and pulses a programming strobe low. The block counts the strobe pulses. It then commits the write to the code array, to a 32-entry key table or to one of two protection bits. Writes are refused when protection forbids them.

Readout during verification is scrambled. Each code byte leaves the block XNORed with the key entry selected by the low five address bits. A key entry that was never programmed therefore passes the byte through unchanged. The key table itself can never be read. Two fixed signature bytes identify the part. A second read port serves instruction fetches from the processor. When the first protection bit is set, this port refuses fetches marked as external. The same bit also freezes the external-access pin level captured during reset.

Storage is modelled as registers that keep their contents through reset. A bulk erase input returns every byte to FFh and clears both protection bits.

Top module: `pmlock_top`

## Requirements
- R1: While and after reset, `rd_data` and `fetch_data` are FFh.
- R2: A programming operation commits only on the 25th strobe pulse. A pulse is counted when `strobe_n` is sampled high after being sampled low. With 24 pulses nothing changes.
- R3: Programming a code byte stores the bitwise AND of the old contents and `wdata`. Bits can only go from 1 to 0.
- R4: The verify operation (`op_pins`=3'b010) returns, one clock later, the bitwise XNOR of the code byte at `addr` with key entry `addr[4:0]`. An erased key (FFh) yields the plain code byte.
- R5: The key-programming operation (`op_pins`=3'b011) writes key entry `addr[4:0]`. Code addresses that share their low five bits are scrambled with the same key.
- R6: Once either protection bit is set, code programming (3'b001) and key programming (3'b011) have no effect. Protection bit 1 (3'b100) and protection bit 2 (3'b101) can each still be programmed after the other.
- R7: With both protection bits set, verify returns FFh. With only bit 1 set, verify still works.
- R8: The key-read operation (3'b111) returns FFh in every state.
- R9: The signature operation (3'b110) returns 89h at address 030h, 57h at 031h and FFh elsewhere.
- R10: With protection bit 1 clear, `ea_eff` follows `ea_pin`. With it set, `ea_eff` holds the `ea_pin` level sampled while `rst_n` was low.
- R11: `fetch_data` returns, one clock later, the code byte at `fetch_addr`. It returns FFh when `fetch_ext` is high and protection bit 1 is set.
- R12: A cycle with `erase` high sets all code bytes and keys to FFh and clears both protection bits. Erase overrides a commit in the same cycle.
- R13: The pulse count clears whenever the operation is not a programming one or changes. Pulses given before the clear do not count towards the 25.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset (storage is kept) |
| erase | input | 1 | Bulk erase of code, keys and protection bits |
| op_pins | input | 3 | Operation: 000 idle, 001 code pgm, 010 verify, 011 key pgm, 100 bit-1 pgm, 101 bit-2 pgm, 110 signature, 111 key read |
| addr | input | CODE_AW | Programmer address |
| wdata | input | 8 | Programmer data byte |
| strobe_n | input | 1 | Programming strobe, pulsed low |
| rd_data | output | 8 | Programmer readout, registered |
| fetch_addr | input | CODE_AW | Processor fetch address |
| fetch_ext | input | 1 | Fetch issued by externally fetched code |
| fetch_data | output | 8 | Fetch result, registered |
| ea_pin | input | 1 | External-access pin level |
| ea_eff | output | 1 | Effective external-access level |

## Verification
The fetch port and a code commit can land on the same clock edge. The bench provokes this by holding `fetch_addr` on the address being programmed while the 25th strobe pulse completes. The fetch result registered on the commit edge must be the old byte, and the result one clock later must be the new one. A write that leaked through combinationally, or that was lost, shows up as a mismatch at one of those two cycles.

// File: rtl/pmlock_pkg.sv
package pmlock_pkg;

  typedef enum logic [2:0] {
    OP_IDLE     = 3'b000,
    OP_PGM_CODE = 3'b001,
    OP_VERIFY   = 3'b010,
    OP_PGM_KEY  = 3'b011,
    OP_PGM_LK1  = 3'b100,
    OP_PGM_LK2  = 3'b101,
    OP_SIG      = 3'b110,
    OP_KEY_RD   = 3'b111
  } op_e;

  localparam logic [15:0] SIG_ADDR0 = 16'h0030;
  localparam logic [15:0] SIG_ADDR1 = 16'h0031;
  localparam logic [7:0]  SIG_BYTE0 = 8'h89;
  localparam logic [7:0]  SIG_BYTE1 = 8'h57;

  function automatic logic [7:0] scramble(input logic [7:0] code, input logic [7:0] key);
    return ~(code ^ key);
  endfunction

  function automatic logic [7:0] burn(input logic [7:0] old_b, input logic [7:0] pat);
    return old_b & pat;
  endfunction

  function automatic logic [7:0] sig_lookup(input logic [15:0] a);
    if (a == SIG_ADDR0) return SIG_BYTE0;
    if (a == SIG_ADDR1) return SIG_BYTE1;
    return 8'hFF;
  endfunction

  function automatic logic is_pgm_op(input op_e op);
    return (op == OP_PGM_CODE) || (op == OP_PGM_KEY) ||
           (op == OP_PGM_LK1)  || (op == OP_PGM_LK2);
  endfunction

endpackage

// File: rtl/pmlock_pulse_cnt.sv
module pmlock_pulse_cnt #(
  parameter int PULSES = 25
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pgm_active,
  input  logic [2:0] op,
  input  logic       strobe_n,
  output logic       done
);
  localparam int CW = $clog2(PULSES + 1);

  logic [CW-1:0] cnt;
  logic [2:0]    op_q;
  logic          strobe_q;
  logic          rise;
  logic          op_changed;

  assign rise       = strobe_n && !strobe_q;
  assign op_changed = (op != op_q);
  assign done       = pgm_active && !op_changed && rise && (cnt == CW'(PULSES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      op_q     <= '0;
      strobe_q <= 1'b1;
    end else begin
      op_q     <= op;
      strobe_q <= strobe_n;
      if (!pgm_active || op_changed || done) cnt <= '0;
      else if (rise)                         cnt <= cnt + 1'b1;
    end
  end

  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(PULSES));
  assert_idle_clears_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !pgm_active |=> cnt == '0);
  assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: rtl/pmlock_guard.sv
module pmlock_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic erase,
  input  logic lk1_set,
  input  logic lk2_set,
  input  logic ea_pin,
  output logic lock1,
  output logic lock2,
  output logic ea_eff
);
  logic ea_hold;

  always_ff @(posedge clk) begin
    if (erase) begin
      lock1 <= 1'b0;
      lock2 <= 1'b0;
    end else begin
      if (lk1_set) lock1 <= 1'b1;
      if (lk2_set) lock2 <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ea_hold <= ea_pin;
  end

  assign ea_eff = lock1 ? ea_hold : ea_pin;

  assert_lock1_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lock1 && !erase) |=> lock1);
  assert_lock2_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lock2 && !erase) |=> lock2);
  assert_ea_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(ea_hold));

endmodule

// File: rtl/pmlock_store.sv
module pmlock_store #(
  parameter int CODE_AW = 9,
  parameter int KEY_AW  = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               erase,
  input  logic               code_we,
  input  logic               key_we,
  input  logic [CODE_AW-1:0] addr,
  input  logic [7:0]         wdata,
  input  logic [CODE_AW-1:0] fetch_addr,
  output logic [7:0]         code_a,
  output logic [7:0]         code_b,
  output logic [7:0]         key_a
);
  import pmlock_pkg::*;

  localparam int CODE_DEPTH = 1 << CODE_AW;
  localparam int KEY_DEPTH  = 1 << KEY_AW;

  logic [7:0] code_mem [CODE_DEPTH];
  logic [7:0] key_mem  [KEY_DEPTH];
  logic [KEY_AW-1:0] kidx;

  assign kidx = addr[KEY_AW-1:0];

  always_ff @(posedge clk) begin
    if (erase) begin
      for (int i = 0; i < CODE_DEPTH; i++) code_mem[i] <= 8'hFF;
      for (int j = 0; j < KEY_DEPTH; j++)  key_mem[j]  <= 8'hFF;
    end else begin
      if (code_we) code_mem[addr] <= burn(code_mem[addr], wdata);
      if (key_we)  key_mem[kidx]  <= burn(key_mem[kidx], wdata);
    end
  end

  assign code_a = code_mem[addr];
  assign code_b = code_mem[fetch_addr];
  assign key_a  = key_mem[kidx];

  assert_erase_blank_R12: assert property (@(posedge clk) disable iff (!rst_n)
    erase |=> (code_a == 8'hFF) && (key_a == 8'hFF));

endmodule

// File: rtl/pmlock_top.sv
module pmlock_top #(
  parameter int CODE_AW = 9,
  parameter int KEY_AW  = 5,
  parameter int PULSES  = 25
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               erase,
  input  logic [2:0]         op_pins,
  input  logic [CODE_AW-1:0] addr,
  input  logic [7:0]         wdata,
  input  logic               strobe_n,
  output logic [7:0]         rd_data,
  input  logic [CODE_AW-1:0] fetch_addr,
  input  logic               fetch_ext,
  output logic [7:0]         fetch_data,
  input  logic               ea_pin,
  output logic               ea_eff
);
  import pmlock_pkg::*;

  op_e        op;
  logic       pgm_active;
  logic       done;
  logic       lock1, lock2, lock_any;
  logic       code_we, key_we, lk1_set, lk2_set;
  logic [7:0] code_a, code_b, key_a;
  logic [7:0] rd_next;

  assign op         = op_e'(op_pins);
  assign pgm_active = is_pgm_op(op);
  assign lock_any   = lock1 | lock2;
  assign code_we    = done && (op == OP_PGM_CODE) && !lock_any;
  assign key_we     = done && (op == OP_PGM_KEY)  && !lock_any;
  assign lk1_set    = done && (op == OP_PGM_LK1);
  assign lk2_set    = done && (op == OP_PGM_LK2);

  pmlock_pulse_cnt #(.PULSES(PULSES)) u_cnt (
    .clk(clk), .rst_n(rst_n), .pgm_active(pgm_active),
    .op(op_pins), .strobe_n(strobe_n), .done(done)
  );

  pmlock_guard u_guard (
    .clk(clk), .rst_n(rst_n), .erase(erase),
    .lk1_set(lk1_set), .lk2_set(lk2_set), .ea_pin(ea_pin),
    .lock1(lock1), .lock2(lock2), .ea_eff(ea_eff)
  );

  pmlock_store #(.CODE_AW(CODE_AW), .KEY_AW(KEY_AW)) u_store (
    .clk(clk), .rst_n(rst_n), .erase(erase),
    .code_we(code_we), .key_we(key_we), .addr(addr), .wdata(wdata),
    .fetch_addr(fetch_addr), .code_a(code_a), .code_b(code_b), .key_a(key_a)
  );

  always_comb begin
    case (op)
      OP_VERIFY: rd_next = (lock1 && lock2) ? 8'hFF : scramble(code_a, key_a);
      OP_SIG:    rd_next = sig_lookup(16'(addr));
      default:   rd_next = 8'hFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data    <= 8'hFF;
      fetch_data <= 8'hFF;
    end else begin
      rd_data    <= rd_next;
      fetch_data <= (fetch_ext && lock1) ? 8'hFF : code_b;
    end
  end

  assert_full_lock_blind_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_VERIFY && lock1 && lock2) |=> rd_data == 8'hFF);
  assert_key_hidden_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_KEY_RD) |=> rd_data == 8'hFF);
  assert_ext_fetch_block_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_ext && lock1) |=> fetch_data == 8'hFF);
  assert_locked_no_code_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lock_any |-> !code_we && !key_we);

endmodule

// File: tb/pmlock_top_test.sv
`timescale 1ns/1ps
module pmlock_top_test;
  localparam int AW = 9;
  localparam logic [2:0] I_IDLE = 3'b000, I_CODE = 3'b001, I_VER = 3'b010,
                         I_KEY = 3'b011, I_LK1 = 3'b100, I_LK2 = 3'b101,
                         I_SIG = 3'b110, I_KRD = 3'b111;

  logic clk = 1'b0;
  logic rst_n = 1'b0, erase = 1'b1, strobe_n = 1'b1, fetch_ext = 1'b0, ea_pin = 1'b0;
  logic [2:0] op_pins = 3'b000;
  logic [AW-1:0] addr = '0, fetch_addr = '0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rd_data, fetch_data, fetch_at_commit, got;
  logic ea_eff;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  pmlock_top uut (
    .clk(clk), .rst_n(rst_n), .erase(erase), .op_pins(op_pins), .addr(addr),
    .wdata(wdata), .strobe_n(strobe_n), .rd_data(rd_data), .fetch_addr(fetch_addr),
    .fetch_ext(fetch_ext), .fetch_data(fetch_data), .ea_pin(ea_pin), .ea_eff(ea_eff)
  );

  // {op, addr, expected}
  localparam int NV = 8;
  localparam logic [19:0] VEC [NV] = '{
    {I_VER, 9'h005, 8'h99},  // R4 ~(3C^5A)
    {I_VER, 9'h025, 8'h00},  // R5 same key index 5: ~(A5^5A)
    {I_VER, 9'h010, 8'h0F},  // R4 erased key gives plain byte
    {I_VER, 9'h045, 8'h5A},  // R4 erased code with key 5A
    {I_SIG, 9'h030, 8'h89},  // R9
    {I_SIG, 9'h031, 8'h57},  // R9
    {I_SIG, 9'h032, 8'hFF},  // R9
    {I_KRD, 9'h005, 8'hFF}   // R8
  };
  localparam string VTAG [NV] = '{"R4", "R5", "R4", "R4", "R9", "R9", "R9", "R8"};

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic pgm(input logic [2:0] op, input logic [AW-1:0] a,
                     input logic [7:0] d, input int n);
    @(negedge clk);
    op_pins = op; addr = a; wdata = d;
    for (int i = 0; i < n; i++) begin
      @(negedge clk) strobe_n = 1'b0;
      @(negedge clk);
      @(negedge clk) strobe_n = 1'b1;
      @(negedge clk);
    end
    fetch_at_commit = fetch_data;
    op_pins = I_IDLE;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input logic [2:0] op, input logic [AW-1:0] a, output logic [7:0] v);
    @(negedge clk);
    op_pins = op; addr = a;
    @(negedge clk);
    v = rd_data;
    op_pins = I_IDLE;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 rd_data in reset", rd_data, 8'hFF);
    erase = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rd_data after reset", rd_data, 8'hFF);
    chk("R1 fetch_data after reset", fetch_data, 8'hFF);
    ea_pin = 1'b1; #1;
    chk("R10 ea follows pin unlocked", {7'b0, ea_eff}, 8'h01);
    ea_pin = 1'b0; #1;
    chk("R10 ea follows pin low", {7'b0, ea_eff}, 8'h00);

    pgm(I_CODE, 9'h005, 8'h3C, 25);
    pgm(I_CODE, 9'h025, 8'hA5, 25);
    pgm(I_CODE, 9'h010, 8'h0F, 25);
    pgm(I_KEY,  9'h0E5, 8'h5A, 25);   // R5 key index = addr[4:0] = 5

    for (int k = 0; k < NV; k++) begin
      rd(VEC[k][19:17], VEC[k][16:8], got);
      chk(VTAG[k], got, VEC[k][7:0]);
    end

    pgm(I_CODE, 9'h010, 8'h03, 24);
    rd(I_VER, 9'h010, got); chk("R2 24 pulses no commit", got, 8'h0F);
    pgm(I_CODE, 9'h010, 8'h03, 1);
    rd(I_VER, 9'h010, got); chk("R13 count cleared by idle", got, 8'h0F);
    pgm(I_CODE, 9'h010, 8'h03, 25);
    rd(I_VER, 9'h010, got); chk("R2 25 pulses commit", got, 8'h03);

    pgm(I_CODE, 9'h005, 8'hF0, 25);
    rd(I_VER, 9'h005, got); chk("R3 AND programming", got, 8'h95);

    fetch_addr = 9'h005; fetch_ext = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R11 internal fetch", fetch_data, 8'h30);
    fetch_ext = 1'b1;
    @(negedge clk);
    chk("R11 external fetch unlocked", fetch_data, 8'h30);

    fetch_addr = 9'h025; fetch_ext = 1'b0;
    pgm(I_CODE, 9'h025, 8'h81, 25);
    chk("R11 fetch on commit edge old", fetch_at_commit, 8'hA5);
    chk("R11 fetch after commit new", fetch_data, 8'h81);

    pgm(I_LK1, 9'h000, 8'h00, 25);
    pgm(I_CODE, 9'h010, 8'h00, 25);
    rd(I_VER, 9'h010, got); chk("R6 code pgm blocked", got, 8'h03);
    pgm(I_KEY, 9'h010, 8'h00, 25);
    rd(I_VER, 9'h010, got); chk("R6 key pgm blocked", got, 8'h03);
    rd(I_VER, 9'h005, got); chk("R7 verify with one lock", got, 8'h95);
    fetch_addr = 9'h005; fetch_ext = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R11 external fetch locked", fetch_data, 8'hFF);
    fetch_ext = 1'b0;
    @(negedge clk);
    chk("R11 internal fetch locked", fetch_data, 8'h30);

    ea_pin = 1'b1;
    @(negedge clk) rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    ea_pin = 1'b0;
    @(negedge clk);
    chk("R10 ea held from reset", {7'b0, ea_eff}, 8'h01);
    chk("R1 rd_data after second reset", rd_data, 8'hFF);

    pgm(I_LK2, 9'h000, 8'h00, 25);
    rd(I_VER, 9'h005, got); chk("R7 verify fully locked", got, 8'hFF);
    rd(I_SIG, 9'h030, got); chk("R9 signature while locked", got, 8'h89);
    rd(I_KRD, 9'h005, got); chk("R8 key read locked", got, 8'hFF);

    @(negedge clk) erase = 1'b1;
    @(negedge clk) erase = 1'b0;
    pgm(I_CODE, 9'h005, 8'h12, 25);
    rd(I_VER, 9'h005, got); chk("R12 erased and unlocked", got, 8'h12);
    #1;
    chk("R12 ea follows pin after erase", {7'b0, ea_eff}, 8'h00);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule